// File: doc/BRIEF.md
# Rate-Scaled ADSR Envelope Generator

This block produces the loudness envelope of one synthesizer voice. The envelope is a 10-bit attenuation value: 0 is full volume and 0x3FF is silence. The voice moves through four phases: attack, first decay, second decay and release. Each phase has its own 5-bit rate. A 4-bit key-rate-scale and the 4-bit octave of the note raise every rate. A 5-bit threshold sets where the first decay hands over to the second.

The block does not count time itself. It watches a free-running global counter that all voices share. The effective rate picks one bit of that counter, and a step happens on a rising edge of the chosen bit. Odd rates below 24 drop some of those edges. The block updates only on cycles that carry the sample tick. A key event input either starts the envelope or sends it to release. A waveform-enable flag tells the sample player to stop fetching once the envelope has decayed to silence.

Top module: `eg_core`

## Requirements
- R1: After reset the level output is 0x3FF, the phase output is release (3) and the waveform-enable output is 0. The phase encoding is attack=0, first decay=1, second decay=2, release=3.
- R2: The key scale is 0 when the key-rate-scale input is 15. Otherwise it is the key-rate-scale plus the octave read as a 4-bit signed number, clamped to 0..15. The effective rate is key scale plus the current phase's rate, capped at 31.
- R3: The counter bit index is (34 - min(24, effective rate)) / 2. A step happens only on a tick where that bit is 1 and was 0 on the previous tick. The stored previous bit is refreshed on every tick, whether or not a step happens.
- R4: For an odd effective rate below 24, a step also needs at least one of the two counter bits just above the index to be 1.
- R5: A phase whose own rate input is 0 never steps, whatever the key scale is.
- R6: Let e be the effective rate clamped to 24..30. The step shift is (32 - e) / 2, plus 1 when e is odd and the counter bit at index+1 is 1. In attack, a step adds the complement of the level, -(level+1), arithmetically shifted right by the shift.
- R7: Outside attack, a step adds 16 shifted right by the step shift, which is always between 1 and 8.
- R8: A step result of 0x3FF or more saturates to 0x3FF and clears the waveform-enable output. A result below 0 saturates to 0.
- R9: On a tick in first decay, if level bits [9:5] equal the decay-level input, the phase becomes second decay before the rate is chosen.
- R10: After the step, attack moves to first decay when the level is 0. When the loop-link input is 1, attack moves to first decay only when the in-loop input is 1, and a level of 0 does not move it.
- R11: A key event with key bit 1 while in release enters attack and sets waveform-enable. The level becomes 0 if attack rate + key scale is 32 or more, and 0x280 otherwise. A key event with key bit 0 while not in release enters release. Any other key event is ignored.
- R12: Without a tick, level, phase and waveform-enable hold their values, even when a key event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample tick; the state advances only on cycles where this is 1 |
| gcnt_i | input | CNT_W | Shared free-running global counter |
| atk_rate_i | input | 5 | Attack rate |
| d1_rate_i | input | 5 | First decay rate |
| d2_rate_i | input | 5 | Second decay rate |
| rel_rate_i | input | 5 | Release rate |
| dlvl_i | input | 5 | Level threshold, compared with level bits [9:5], that ends first decay |
| krs_i | input | 4 | Key-rate-scale (15 disables scaling) |
| octave_i | input | 4 | Note octave, 4-bit signed |
| loop_link_i | input | 1 | Ends attack at loop entry instead of at level 0 |
| in_loop_i | input | 1 | Voice playback is inside its loop |
| key_exec_i | input | 1 | Key event strobe |
| key_bit_i | input | 1 | Key event value: 1 = key-on, 0 = key-off |
| level_o | output | 10 | Attenuation level |
| phase_o | output | 2 | Current phase |
| wave_on_o | output | 1 | Waveform fetch enable |

## Verification
The step rules decide every change in level, so a fault in them shows up at the ports quickly. A wrong counter bit index, a lost odd-rate gate or a stale stored edge bit makes the level step on the wrong tick, and the very next tick's level differs from the model. A wrong shift or increment gives a wrong level size within one step. A bad phase transition shows up as a wrong phase code on the tick where the threshold, the zero level or the loop entry is met. From then on the wrong rate keeps the error growing.

// File: rtl/eg_pkg.sv
package eg_pkg;
   localparam int LVL_W  = 10;
   localparam int RATE_W = 5;
   localparam int KRS_W  = 4;

   localparam logic [LVL_W-1:0] LVL_SILENT    = {LVL_W{1'b1}};
   localparam logic [LVL_W-1:0] LVL_ATK_START = 10'h280;

   typedef enum logic [1:0] {
      PH_ATK = 2'd0,
      PH_D1  = 2'd1,
      PH_D2  = 2'd2,
      PH_REL = 2'd3
   } eg_phase_e;
endpackage

// File: rtl/eg_rate.sv
module eg_rate
   import eg_pkg::*;
#(
   parameter bit KS_EN = 1'b1
)(
   input  logic [KRS_W-1:0]  krs_i,
   input  logic [KRS_W-1:0]  octave_i,
   input  logic [RATE_W-1:0] raw_i,
   output logic [KRS_W-1:0]  ks_o,
   output logic [RATE_W-1:0] eff_o
);
   localparam int SUM_W = RATE_W + 1;
   localparam int KS_MAX = (1 << KRS_W) - 1;
   localparam int RATE_MAX = (1 << RATE_W) - 1;

   generate
      if (KS_EN) begin : g_scale
         logic signed [KRS_W+1:0] sum;
         always_comb begin
            sum = $signed({2'b00, krs_i}) + $signed({{2{octave_i[KRS_W-1]}}, octave_i});
            if (krs_i == KRS_W'(KS_MAX))   ks_o = '0;
            else if (sum < 0)              ks_o = '0;
            else if (sum > KS_MAX)         ks_o = KRS_W'(KS_MAX);
            else                           ks_o = sum[KRS_W-1:0];
         end
      end else begin : g_noscale
         assign ks_o = '0;
      end
   endgenerate

   logic [SUM_W-1:0] tot;
   assign tot   = SUM_W'(ks_o) + SUM_W'(raw_i);
   assign eff_o = (tot > SUM_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : tot[RATE_W-1:0];
endmodule

// File: rtl/eg_clock.sv
module eg_clock
   import eg_pkg::*;
#(
   parameter int CNT_W = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              raw_nz_i,
   output logic              step_o,
   output logic [2:0]        shift_o
);
   localparam int IDX_W = $clog2(CNT_W);

   logic [RATE_W-1:0] r_lo, r_em;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  sel;
   logic              cur, prev_q, odd_low;

   always_comb begin
      r_lo    = (rate_i < 5'd24) ? rate_i : 5'd24;
      idx     = IDX_W'((6'd34 - {1'b0, r_lo}) >> 1);
      sel     = cnt_i >> idx;
      cur     = sel[0];
      odd_low = rate_i[0] && (rate_i < 5'd24);
      step_o  = cur && !prev_q && raw_nz_i && (!odd_low || (sel[2:1] != 2'b00));
      if (rate_i < 5'd24)      r_em = 5'd24;
      else if (rate_i > 5'd30) r_em = 5'd30;
      else                     r_em = rate_i;
      shift_o = 3'((6'd32 - {1'b0, r_em}) >> 1) + {2'b00, r_em[0] & sel[1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (tick_i) prev_q <= cur;
   end
endmodule

// File: rtl/eg_core.sv
module eg_core
   import eg_pkg::*;
#(
   parameter int CNT_W = 20,
   parameter bit KS_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  gcnt_i,
   input  logic [4:0]        atk_rate_i,
   input  logic [4:0]        d1_rate_i,
   input  logic [4:0]        d2_rate_i,
   input  logic [4:0]        rel_rate_i,
   input  logic [4:0]        dlvl_i,
   input  logic [3:0]        krs_i,
   input  logic [3:0]        octave_i,
   input  logic              loop_link_i,
   input  logic              in_loop_i,
   input  logic              key_exec_i,
   input  logic              key_bit_i,
   output logic [9:0]        level_o,
   output logic [1:0]        phase_o,
   output logic              wave_on_o
);
   generate
      if (CNT_W < 20) begin : g_cnt_chk
         $error("eg_core: CNT_W must cover counter bit 19");
      end
   endgenerate

   localparam int SW = LVL_W + 2;

   eg_phase_e          phase_q, ph_a, ph_b, phase_n;
   logic [LVL_W-1:0]   level_q, lvl_b, level_n;
   logic               wave_q, wave_b, wave_n;
   logic [RATE_W-1:0]  raw, eff;
   logic [KRS_W-1:0]   ks;
   logic               step;
   logic [2:0]         shift;
   logic signed [SW-1:0] lv_s, inc, sum;
   logic [RATE_W:0]    atk_sum;

   // phase after the decay-level test, used for rate selection
   always_comb begin
      ph_a = phase_q;
      if (phase_q == PH_D1 && level_q[LVL_W-1:LVL_W-5] == dlvl_i) ph_a = PH_D2;
      unique case (ph_a)
         PH_ATK:  raw = atk_rate_i;
         PH_D1:   raw = d1_rate_i;
         PH_D2:   raw = d2_rate_i;
         default: raw = rel_rate_i;
      endcase
   end

   eg_rate #(.KS_EN(KS_EN)) u_rate (
      .krs_i(krs_i), .octave_i(octave_i), .raw_i(raw), .ks_o(ks), .eff_o(eff)
   );

   eg_clock #(.CNT_W(CNT_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_i(gcnt_i),
      .rate_i(eff), .raw_nz_i(raw != '0), .step_o(step), .shift_o(shift)
   );

   always_comb begin
      lv_s = SW'(level_q);
      if (ph_a == PH_ATK) inc = (~lv_s) >>> shift;
      else                inc = 12'sd16 >>> shift;
      sum    = lv_s + inc;
      lvl_b  = level_q;
      wave_b = wave_q;
      if (step) begin
         if (sum >= 12'sd1023) begin
            lvl_b  = LVL_SILENT;
            wave_b = 1'b0;
         end else if (sum < 0) begin
            lvl_b  = '0;
         end else begin
            lvl_b  = sum[LVL_W-1:0];
         end
      end
      ph_b = ph_a;
      if (ph_a == PH_ATK && (loop_link_i ? in_loop_i : (lvl_b == '0))) ph_b = PH_D1;

      atk_sum = {1'b0, atk_rate_i} + (RATE_W+1)'(ks);
      phase_n = ph_b;
      level_n = lvl_b;
      wave_n  = wave_b;
      if (key_exec_i && ((ph_b == PH_REL) == key_bit_i)) begin
         if (key_bit_i) begin
            phase_n = PH_ATK;
            wave_n  = 1'b1;
            level_n = (atk_sum >= 6'd32) ? '0 : LVL_ATK_START;
         end else begin
            phase_n = PH_REL;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_SILENT;
         phase_q <= PH_REL;
         wave_q  <= 1'b0;
      end else if (tick_i) begin
         level_q <= level_n;
         phase_q <= phase_n;
         wave_q  <= wave_n;
      end
   end

   assign level_o   = level_q;
   assign phase_o   = phase_q;
   assign wave_on_o = wave_q;

   // R12: state frozen between ticks
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(level_o) && $stable(phase_o) && $stable(wave_on_o)));

   // R8: reaching silence turns waveform fetch off
   a_r8_silence_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o == 10'h3FF && $past(level_o) != 10'h3FF) |-> !wave_on_o);

   // R11: key-on from release starts attack at one of two levels
   a_r11_key_on: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && key_exec_i && key_bit_i && phase_o == 2'd3) |=>
      (phase_o == 2'd0 && wave_on_o && (level_o == 10'h000 || level_o == 10'h280)));

   // R7: non-attack steps only raise the level, by at most 8
   a_r7_decay_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !key_exec_i && phase_o != 2'd0) |=>
      (level_o >= $past(level_o) && {1'b0, level_o} <= {1'b0, $past(level_o)} + 11'd8));

   // R6: attack steps never lower the volume
   a_r6_attack_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !key_exec_i && phase_o == 2'd0) |=> level_o <= $past(level_o));
endmodule

// File: tb/sim_eg_core.sv
module sim_eg_core;
   localparam int CLK_PER = 10;
   localparam int CW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [CW-1:0] gcnt = '0;
   logic [4:0]    atk = 5'd0, d1 = 5'd0, d2 = 5'd0, rel = 5'd0, dl = 5'd31;
   logic [3:0]    krs = 4'hF, oct = 4'd0;
   logic          link = 1'b0, inloop = 1'b0, kx = 1'b0, kb = 1'b0;
   logic [9:0]    level;
   logic [1:0]    phase;
   logic          wave;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference state built from the requirements
   int  m_lvl = 1023;
   int  m_ph = 3;
   bit  m_wave = 0;
   bit  m_prev = 0;

   logic [12:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PER/2) clk = ~clk;

   eg_core #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .gcnt_i(gcnt),
      .atk_rate_i(atk), .d1_rate_i(d1), .d2_rate_i(d2), .rel_rate_i(rel),
      .dlvl_i(dl), .krs_i(krs), .octave_i(oct), .loop_link_i(link),
      .in_loop_i(inloop), .key_exec_i(kx), .key_bit_i(kb),
      .level_o(level), .phase_o(phase), .wave_on_o(wave)
   );

   task automatic chk(input string tag, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   function automatic int key_scale();
      int s;
      if (krs == 4'hF) return 0;
      s = int'(krs) + ((oct >= 4'd8) ? int'(oct) - 16 : int'(oct));
      if (s < 0) s = 0;
      if (s > 15) s = 15;
      return s;
   endfunction

   // advance the reference by one tick using current inputs
   task automatic model_tick();
      int ks, ph, raw, r, idx, cur, hi, em, sh, inc, n;
      bit st;
      ks = key_scale();
      ph = m_ph;
      if (ph == 1 && (m_lvl >> 5) == int'(dl)) ph = 2;          // R9
      case (ph)
         0: raw = int'(atk);
         1: raw = int'(d1);
         2: raw = int'(d2);
         default: raw = int'(rel);
      endcase
      r = ks + raw; if (r > 31) r = 31;                          // R2
      idx = (34 - ((r < 24) ? r : 24)) / 2;                      // R3
      cur = int'((gcnt >> idx) & 1);
      hi  = int'((gcnt >> (idx + 1)) & 3);
      st = (m_prev == 0) && (cur == 1) && (raw != 0)             // R5
           && !((r < 24) && (r % 2 == 1) && (hi == 0));          // R4
      m_prev = cur[0];
      n = m_lvl;
      if (st) begin
         em = (r < 24) ? 24 : ((r > 30) ? 30 : r);
         sh = (32 - em) / 2 + ((em % 2) & (hi & 1));              // R6
         if (ph == 0) inc = (-(m_lvl + 1)) >>> sh;
         else         inc = 16 >> sh;                             // R7
         n = m_lvl + inc;
         if (n >= 1023) begin n = 1023; m_wave = 0; end          // R8
         if (n < 0) n = 0;
      end
      m_lvl = n;
      if (ph == 0 && (link ? inloop : (n == 0))) ph = 1;         // R10
      if (kx && ((ph == 3) == kb)) begin                         // R11
         if (kb) begin
            ph = 0; m_wave = 1;
            m_lvl = (int'(atk) + ks >= 32) ? 0 : 640;
         end else ph = 3;
      end
      m_ph = ph;
   endtask

   // driver: one ticked cycle, expected result pushed to the scoreboard
   task automatic do_tick(input int cnt, input bit x, input bit b, input string tag);
      @(negedge clk);
      gcnt = CW'(cnt); kx = x; kb = b; tick = 1'b1;
      model_tick();
      exp_q.push_back({m_wave, 2'(m_ph), 10'(m_lvl)});
      tag_q.push_back(tag);
      @(posedge clk); #2;
      tick = 1'b0; kx = 1'b0;
   endtask

   task automatic pairs(input int n, input int lo, input int hi, input string tag);
      for (int i = 0; i < n; i++) begin
         do_tick(hi, 0, 0, tag);
         do_tick(lo, 0, 0, tag);
      end
   endtask

   // monitor: compare each ticked result
   initial begin
      logic [12:0] e;
      string t;
      forever begin
         @(posedge clk);
         if (tick && rst_n) begin
            #1;
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL scoreboard: actual=0x%0h expected=none", {wave, phase, level});
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, int'({wave, phase, level}), int'(e));
            end
         end
      end
   end

   initial begin
      #(CLK_PER * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hold;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset level", int'(level), 'h3FF);
      chk("R1 reset phase", int'(phase), 3);
      chk("R1 reset wave", int'(wave), 0);
      @(negedge clk); rst_n = 1'b1;

      // R12: key event without tick has no effect
      @(negedge clk); kx = 1'b1; kb = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk("R12 no tick level", int'(level), 'h3FF);
      chk("R12 no tick phase", int'(phase), 3);
      @(negedge clk); kx = 1'b0;

      // R2/R11: key-on, scaling off, attack 0x1F -> start level 0x280
      atk = 5'h1F; d1 = 5'd0; krs = 4'hF;
      do_tick(0, 1, 1, "R11 key on");
      chk("R2 start level 0x280", int'(level), 'h280);
      chk("R11 attack phase", int'(phase), 0);
      chk("R11 wave on", int'(wave), 1);

      // R6/R10: exponential attack down to 0, then first decay
      pairs(12, 0, 32, "R6 attack steps");
      chk("R10 attack end level", int'(level), 0);
      chk("R10 attack to decay1", int'(phase), 1);

      // R9/R7: decay1 to threshold then decay2
      d1 = 5'h1E; d2 = 5'h1C; dl = 5'd1;
      pairs(8, 0, 32, "R9 decay steps");
      chk("R9 decay2 phase", int'(phase), 2);
      chk("R7 decay level", int'(level), 48);

      // R5: release with zero rate but nonzero key scale never steps
      krs = 4'd4; oct = 4'd0; rel = 5'd0;
      do_tick(0, 1, 0, "R11 key off");
      chk("R11 release phase", int'(phase), 3);
      hold = int'(level);
      pairs(4, 0, 32, "R5 zero rate");
      chk("R5 level held", int'(level), hold);

      // R8: release to silence
      rel = 5'h1F;
      pairs(130, 0, 32, "R8 release steps");
      chk("R8 saturate level", int'(level), 'h3FF);
      chk("R8 wave off", int'(wave), 0);

      // R2: key scale 4 + attack 0x1C reaches 32 -> start at 0
      atk = 5'h1C;
      do_tick(0, 1, 1, "R2 key on scaled");
      chk("R2 start level 0", int'(level), 0);
      krs = 4'hF; d1 = 5'h11; dl = 5'd31;
      do_tick(0, 0, 0, "R10 zero level");
      chk("R10 decay1 phase", int'(phase), 1);

      // R4: odd low rate gating, R3 edge memory
      do_tick('h100, 0, 0, "R4 gated");
      chk("R4 gated no step", int'(level), 0);
      do_tick('h200, 0, 0, "R4 low");
      do_tick('h300, 0, 0, "R4 pass");
      chk("R4 ungated step", int'(level), 1);
      do_tick('h300, 0, 0, "R3 no edge");
      chk("R3 level bit held high", int'(level), 1);

      // R11: key-on outside release ignored
      do_tick(0, 1, 1, "R11 ignored");
      chk("R11 ignored phase", int'(phase), 1);
      chk("R11 ignored level", int'(level), 1);

      // R10: loop link holds attack at level 0 until loop entry
      rel = 5'd0;
      do_tick(0, 1, 0, "R11 key off 2");
      atk = 5'h1F; link = 1'b1; inloop = 1'b0;
      do_tick(0, 1, 1, "R10 link key on");
      pairs(12, 0, 32, "R10 link attack");
      chk("R10 linked level 0", int'(level), 0);
      chk("R10 linked stays attack", int'(phase), 0);
      inloop = 1'b1;
      do_tick(0, 0, 0, "R10 loop entry");
      chk("R10 loop entry decay1", int'(phase), 1);

      // R6: odd rate with shift bit at index+1
      link = 1'b0; inloop = 1'b0;
      do_tick(0, 1, 0, "R11 key off 3");
      atk = 5'h1D;
      do_tick(0, 1, 1, "R6 key on odd");
      for (int i = 0; i < 10; i++) begin
         do_tick(32, 0, 0, "R6 odd shift lo");
         do_tick(64, 0, 0, "R6 odd idle");
         do_tick(96, 0, 0, "R6 odd shift hi");
         do_tick(0, 0, 0, "R6 odd idle");
      end

      repeat (2) @(posedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule